// File: doc/BRIEF.md
# Iterative Segmented Karatsuba Polynomial Multiplier

This block multiplies two binary polynomials of `WIDTH` coefficients each (arithmetic over GF(2), so addition is XOR) and returns the unreduced product of `2*WIDTH-1` coefficients. It does not build a full-size multiplier. Instead, each operand is cut into four equal segments, zero-padded at the top when `WIDTH` is not a multiple of four. One small combinational carry-less core, a quarter of the operand width, is then reused over nine consecutive clock cycles, following a two-level Karatsuba schedule.

In each cycle, a sequencer emits two small control words. The first is a 4-bit segment mask. It tells the operand selector which segments of each operand to XOR together as the core's input. The second is a 7-bit placement word. It tells the accumulator at which of seven segment-aligned offsets the core's partial product is XORed into the running result. The accumulator is a regular two-stage XOR network. The first stage handles the even offsets and the second stage handles the odd offsets, so the partial products inside each stage never overlap. Only the second stage's output is registered, and that register feeds back in the next cycle.

A user drives both operands together with a one-cycle `start` while the block is idle. The user then waits for the one-cycle `done` pulse and reads `product`, which holds its value until the next accepted start.

Top module: `karatsuba_iter_mul`

## Requirements
- R1: After a run, `product` equals the carry-less (GF(2)) product of the operands captured at acceptance. Bit k of `product` is the XOR over all i+j=k of `op_a[i] & op_b[j]`.
- R2: A start is accepted at a rising edge where `start` is 1 and no run is in progress. `done` is 0 after each of the following eight edges and is 1 after the ninth edge.
- R3: `done` is high for exactly one clock cycle per run.
- R4: `start` is ignored while a run is in progress. Neither the result nor the timing of the current run changes, even if the operand inputs change.
- R5: Once `done` has pulsed, `product` and `done` stay unchanged until the next accepted start, whatever the operand inputs do.
- R6: The accumulator is cleared when a start is accepted, so `product` reads 0 in the cycle after acceptance.
- R7: After reset, `done` is 0 and `product` is 0.
- R8: A start raised in the same cycle as `done` is accepted, so runs can follow each other with no idle cycle between them.
- R9: Operand widths that are not a multiple of four give correct products; the padding segments contribute nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; taken only when idle |
| op_a | input | WIDTH | First operand polynomial, bit i = coefficient of x^i |
| op_b | input | WIDTH | Second operand polynomial |
| product | output | 2*WIDTH-1 | Running accumulator; the final product once done pulses |
| done | output | 1 | One-cycle pulse marking a finished product |

## Verification
The bench builds the block with `WIDTH` = 6. This gives a 2-bit core and operands padded from 6 to 8 bits, so every one of the 4096 operand pairs can be run, and every run is started in the `done` cycle of the run before it. The sweep therefore covers every value each selector combination can present to the core, every placement overlap across the two XOR stages, and the padding path. Targeted runs add a start during a run with changed operands, a long idle stretch with moving inputs, and the reset state.

// File: rtl/kara_pkg.sv
package kara_pkg;

    localparam int NUM_SEG  = 4;
    localparam int NUM_POS  = 2 * NUM_SEG - 1;
    localparam int NUM_STEP = 9;
    localparam int STEP_W   = $clog2(NUM_STEP);

    // Offset (in segments) at which each step's partial product is folded in.
    // Bit k set means "XOR the partial product in at k segments up".
    function automatic logic [NUM_POS-1:0] step_place(input logic [STEP_W-1:0] step);
        logic [NUM_POS-1:0] w;
        case (step)
            4'd0:    w = 7'b0001111; // s0*t0
            4'd1:    w = 7'b1111000; // s3*t3
            4'd2:    w = 7'b0011110; // s1*t1
            4'd3:    w = 7'b0111100; // s2*t2
            4'd4:    w = 7'b0001010; // (s0^s1)*(t0^t1)
            4'd5:    w = 7'b0101000; // (s2^s3)*(t2^t3)
            4'd6:    w = 7'b0011000; // (s1^s3)*(t1^t3)
            4'd7:    w = 7'b0001100; // (s0^s2)*(t0^t2)
            4'd8:    w = 7'b0001000; // all four segments
            default: w = '0;
        endcase
        return w;
    endfunction

    // Which operand segments are XORed together for the core in each step.
    function automatic logic [NUM_SEG-1:0] step_mask(input logic [STEP_W-1:0] step);
        logic [NUM_SEG-1:0] m;
        case (step)
            4'd0:    m = 4'b0001;
            4'd1:    m = 4'b1000;
            4'd2:    m = 4'b0010;
            4'd3:    m = 4'b0100;
            4'd4:    m = 4'b0011;
            4'd5:    m = 4'b1100;
            4'd6:    m = 4'b1010;
            4'd7:    m = 4'b0101;
            4'd8:    m = 4'b1111;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/kara_seq.sv
module kara_seq
    import kara_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              load,
    output logic              done,
    output logic [NUM_SEG-1:0] mask,
    output logic [NUM_POS-1:0] place
);

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        load       = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                load       = 1'b1;
                seq_d.busy = 1'b1;
                seq_d.step = '0;
            end
        end else if (seq_q.step == STEP_W'(NUM_STEP - 1)) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
            seq_d.step = '0;
        end else begin
            seq_d.step = seq_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy  = seq_q.busy;
    assign done  = seq_q.done;
    assign mask  = step_mask(seq_q.step);
    assign place = seq_q.busy ? step_place(seq_q.step) : '0;

endmodule

// File: rtl/kara_opsel.sv
module kara_opsel
    import kara_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic [NUM_SEG*SEG_W-1:0] op,
    input  logic [NUM_SEG-1:0]       mask,
    output logic [SEG_W-1:0]         sel
);

    always_comb begin
        sel = '0;
        for (int s = 0; s < NUM_SEG; s++) begin
            if (mask[s]) sel = sel ^ op[s*SEG_W +: SEG_W];
        end
    end

endmodule

// File: rtl/kara_core.sv
module kara_core #(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W-1:0]   x,
    input  logic [SEG_W-1:0]   y,
    output logic [2*SEG_W-2:0] p
);

    always_comb begin
        p = '0;
        for (int i = 0; i < SEG_W; i++) begin
            for (int j = 0; j < SEG_W; j++) begin
                p[i+j] = p[i+j] ^ (x[i] & y[j]);
            end
        end
    end

endmodule

// File: rtl/kara_accum.sv
module kara_accum
    import kara_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic [NUM_SEG*2*SEG_W-2:0] acc_q,
    input  logic [2*SEG_W-2:0]         pp,
    input  logic [NUM_POS-1:0]         place,
    output logic [NUM_SEG*2*SEG_W-2:0] acc_d
);

    localparam int ACC_W = NUM_SEG * 2 * SEG_W - 1;

    logic [ACC_W-1:0] lane [NUM_POS];
    logic [ACC_W-1:0] stage1;

    for (genvar k = 0; k < NUM_POS; k++) begin : g_lane
        assign lane[k] = place[k] ? (ACC_W'(pp) << (k * SEG_W)) : '0;
    end

    // Even offsets never overlap each other, nor do odd ones: two flat stages.
    always_comb begin
        stage1 = acc_q;
        for (int k = 0; k < NUM_POS; k += 2) stage1 = stage1 ^ lane[k];
        acc_d = stage1;
        for (int k = 1; k < NUM_POS; k += 2) acc_d = acc_d ^ lane[k];
    end

endmodule

// File: rtl/karatsuba_iter_mul.sv
module karatsuba_iter_mul
    import kara_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-2:0] product,
    output logic               done
);

    localparam int SEG_W  = (WIDTH + NUM_SEG - 1) / NUM_SEG;
    localparam int PAD_W  = NUM_SEG * SEG_W;
    localparam int ACC_W  = 2 * PAD_W - 1;
    localparam int PROD_W = 2 * WIDTH - 1;

    typedef struct packed {
        logic [PAD_W-1:0] a;
        logic [PAD_W-1:0] b;
        logic [ACC_W-1:0] acc;
    } dp_t;

    dp_t dp_d, dp_q;

    logic               busy;
    logic               load;
    logic [NUM_SEG-1:0] mask;
    logic [NUM_POS-1:0] place;
    logic [SEG_W-1:0]   core_x, core_y;
    logic [2*SEG_W-2:0] core_p;
    logic [ACC_W-1:0]   acc_next;

    kara_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .load  (load),
        .done  (done),
        .mask  (mask),
        .place (place)
    );

    kara_opsel #(.SEG_W(SEG_W)) u_sel_a (.op(dp_q.a), .mask(mask), .sel(core_x));
    kara_opsel #(.SEG_W(SEG_W)) u_sel_b (.op(dp_q.b), .mask(mask), .sel(core_y));

    kara_core #(.SEG_W(SEG_W)) u_core (.x(core_x), .y(core_y), .p(core_p));

    kara_accum #(.SEG_W(SEG_W)) u_acc (
        .acc_q (dp_q.acc),
        .pp    (core_p),
        .place (place),
        .acc_d (acc_next)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.a   = PAD_W'(op_a);
            dp_d.b   = PAD_W'(op_b);
            dp_d.acc = '0;
        end else if (busy) begin
            dp_d.acc = acc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign product = dp_q.acc[PROD_W-1:0];

    if (ACC_W > PROD_W) begin : g_pad_hi
        logic unused_pad_hi;
        assign unused_pad_hi = ^dp_q.acc[ACC_W-1:PROD_W];
    end

endmodule

// File: rtl/karatsuba_iter_mul_chk.sv
module karatsuba_iter_mul_chk #(
    parameter int PAD_W  = 16,
    parameter int PROD_W = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [PAD_W-1:0]  hold_a,
    input logic [PAD_W-1:0]  hold_b,
    input logic [PROD_W-1:0] product
);

    // R2
    latency_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##10 done);

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    operands_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(hold_a) && $stable(hold_b)));

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    // R6
    clear_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (product == '0));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind karatsuba_iter_mul karatsuba_iter_mul_chk #(
    .PAD_W  (PAD_W),
    .PROD_W (PROD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .hold_a  (dp_q.a),
    .hold_b  (dp_q.b),
    .product (product)
);

// File: tb/karatsuba_iter_mul_tb.sv
module karatsuba_iter_mul_tb;

    localparam int W      = 6;
    localparam int PW     = 2 * W - 1;
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [PW-1:0] product;
    logic          done;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_NS / 2) clk = ~clk;

    karatsuba_iter_mul #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product),
        .done    (done)
    );

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [PW-1:0] r = '0;
        for (int i = 0; i < W; i++)
            if (a[i]) r = r ^ (PW'(b) << i);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negative edge; returns at the negative edge of the done cycle.
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit disturb, input bit full_checks);
        bit early = 1'b0;
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (full_checks) check(product == '0, "R6 cleared after accept", 64'(product), 64'd0);
        for (int i = 0; i < 9; i++) begin
            if (done) early = 1'b1;
            if (disturb && i == 3) begin
                op_a  = ~a;
                op_b  = b ^ 6'h15;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(!early, "R2 done early", 64'(early), 64'd0);
        check(done == 1'b1, "R2 done after ninth edge", 64'(done), 64'd1);
        check(product == ref_mul(a, b), disturb ? "R4 product despite mid-run start" : "R1 R9 product",
              64'(product), 64'(ref_mul(a, b)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [PW-1:0] held;
        repeat (3) @(negedge clk);
        // R7
        check(done == 1'b0, "R7 done in reset", 64'(done), 64'd0);
        check(product == '0, "R7 product in reset", 64'(product), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && product == '0, "R7 after reset release", 64'(product), 64'd0);

        run(6'h2D, 6'h33, 1'b0, 1'b1);
        @(negedge clk);
        // R3
        check(done == 1'b0, "R3 done one cycle", 64'(done), 64'd0);

        // R5: idle with moving inputs
        held = product;
        for (int k = 0; k < 6; k++) begin
            op_a = 6'(k * 11);
            op_b = 6'(k * 7 + 3);
            @(negedge clk);
            check(product == held && done == 1'b0, "R5 idle holds", 64'(product), 64'(held));
        end

        // R4: start while busy with different operands
        run(6'h3F, 6'h29, 1'b1, 1'b1);
        // R8: next run begins in the done cycle
        run(6'h3F, 6'h3F, 1'b0, 1'b1);
        check(product == ref_mul(6'h3F, 6'h3F), "R8 back-to-back", 64'(product), 64'(ref_mul(6'h3F, 6'h3F)));

        // R1 R9 R8: exhaustive sweep, each run started in the previous done cycle
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run(6'(a), 6'(b), 1'b0, (a == b));
            end
        end
        @(negedge clk);
        check(done == 1'b0, "R3 done low after sweep", 64'(done), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule